// File: doc/BRIEF.md
# Four-Way Streaming Merge Sorter

This block takes several lists of (key, value) records, each already in ascending key order, and merges them into one ascending stream. The lists arrive on separate input lanes and the merged stream leaves on one output port. Inside, a binary tree of two-input merge cells sits between the lanes and the output. Each cell holds a one-record register per input, so every level of the tree is one pipeline stage. With the lanes and the consumer never stalling, one record leaves per clock.

The last record of each list carries an end flag. A lane that has finished is treated as holding a key larger than any real key, so the remaining lanes drain without waiting for it. The output marks each record whose key equals the key of the record just before it in the same batch, so a downstream accumulator can combine the two. After the final merged record is accepted, a one-cycle done pulse follows. Each list must hold at least one record. `WAYS` must be a power of two, at least 2.

Every lane and the output use valid/ready. A transfer happens on a clock edge where both are high. A source may raise or drop valid at any time, and its data matters only while valid is high. While the output is valid and ready is low, the output record is held unchanged. A lane that has delivered its end-flagged record shows ready low until the merge of the current batch has moved past it, so records from the next batch never mix with the current one.

Top module: `kway_merge_sorter`

## Requirements
- R1: Within one batch, the keys of successive output records never decrease.
- R2: Records with equal keys leave in order of lane number, lowest lane first. Records from one lane keep their input order.
- R3: Every accepted input record leaves exactly once, whatever stalls the lanes and the consumer apply. While `out_valid` is high and `out_ready` is low, all output fields stay unchanged on the next cycle.
- R4: When every lane offers its next record each cycle and `out_ready` stays high, a batch of N records leaves on N consecutive clock cycles.
- R5: `out_same_key` is 1 exactly when the record's key equals the key of the previous output record of the same batch. It is 0 on the first record of every batch.
- R6: A lane's end flag on its final record marks that list as finished. The other lanes then merge on without waiting for it. `out_last` is 1 on the final record of the batch and 0 on every other record.
- R7: `done` is high for exactly one cycle, on the cycle after the record with `out_last` is accepted, and is low at all other times.
- R8: On the cycle after a lane's end-flagged record is accepted, that lane's `lane_ready` is low.
- R9: After reset, `out_valid` and `done` are 0 and every `lane_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lane_valid | input | WAYS | Per-lane record valid |
| lane_ready | output | WAYS | Per-lane record accepted when high with valid |
| lane_key | input | WAYS x KEY_W | Per-lane sort key |
| lane_val | input | WAYS x VAL_W | Per-lane payload |
| lane_last | input | WAYS | Per-lane end-of-list flag on the final record |
| out_valid | output | 1 | Merged record valid |
| out_ready | input | 1 | Consumer accepts the merged record |
| out_key | output | KEY_W | Merged record key |
| out_val | output | VAL_W | Merged record payload |
| out_last | output | 1 | Final record of the merged batch |
| out_same_key | output | 1 | Key equals the previous record's key in this batch |
| done | output | 1 | One-cycle pulse after the batch completes |

## Verification
Interleaved lists with distinct keys test the ordering. With every source and the consumer running flat out, they also show whether the tree sustains one record per cycle. Lists made mostly of equal keys separate a stable tie break from an unstable one, and they exercise the same-key flag. They are followed by a batch that opens on the previous batch's last key, which tests that the flag is cleared at the batch boundary. One long list against single-record lists exercises the exhausted-lane rule. Random keys with random lane gaps and consumer stalls expose lost, repeated or changed records under back-pressure.

// File: rtl/merge_pkg.sv
`timescale 1ns/1ps
package merge_pkg;
  // Which buffered input a merge cell forwards this cycle.
  typedef enum logic {
    PICK_L = 1'b0,
    PICK_R = 1'b1
  } pick_e;
endpackage

// File: rtl/merge_cell.sv
`timescale 1ns/1ps
module merge_cell
  import merge_pkg::*;
#(
  parameter int KEY_W = 16,
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             l_valid,
  output logic             l_ready,
  input  logic [KEY_W-1:0] l_key,
  input  logic [VAL_W-1:0] l_val,
  input  logic             l_last,
  input  logic             r_valid,
  output logic             r_ready,
  input  logic [KEY_W-1:0] r_key,
  input  logic [VAL_W-1:0] r_val,
  input  logic             r_last,
  output logic             o_valid,
  input  logic             o_ready,
  output logic [KEY_W-1:0] o_key,
  output logic [VAL_W-1:0] o_val,
  output logic             o_last
);
  // one-record buffer per side
  logic             lb_v, rb_v;
  logic [KEY_W-1:0] lb_k, rb_k;
  logic [VAL_W-1:0] lb_d, rb_d;
  logic             lb_l, rb_l;
  // side has delivered its end-flagged record in this batch
  logic             l_done, r_done;

  logic  l_ok, r_ok, fire, take_l, take_r;
  pick_e pick;

  // a finished side counts as +infinity; ties go left
  assign l_ok = lb_v && (r_done || (rb_v && (lb_k <= rb_k)));
  assign r_ok = rb_v && (l_done || (lb_v && (rb_k < lb_k)));
  assign pick = l_ok ? PICK_L : PICK_R;

  assign o_valid = l_ok || r_ok;
  assign o_key   = (pick == PICK_L) ? lb_k : rb_k;
  assign o_val   = (pick == PICK_L) ? lb_d : rb_d;
  assign o_last  = (pick == PICK_L) ? (lb_l && r_done) : (rb_l && l_done);

  assign fire   = o_valid && o_ready;
  assign take_l = fire && l_ok;
  assign take_r = fire && r_ok;

  // no refill behind an end-flagged record until the batch moves on
  assign l_ready = !l_done && (!lb_v || (take_l && !lb_l));
  assign r_ready = !r_done && (!rb_v || (take_r && !rb_l));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lb_v <= 1'b0;
      lb_k <= '0;
      lb_d <= '0;
      lb_l <= 1'b0;
    end else if (l_valid && l_ready) begin
      lb_v <= 1'b1;
      lb_k <= l_key;
      lb_d <= l_val;
      lb_l <= l_last;
    end else if (take_l) begin
      lb_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_v <= 1'b0;
      rb_k <= '0;
      rb_d <= '0;
      rb_l <= 1'b0;
    end else if (r_valid && r_ready) begin
      rb_v <= 1'b1;
      rb_k <= r_key;
      rb_d <= r_val;
      rb_l <= r_last;
    end else if (take_r) begin
      rb_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_done <= 1'b0;
      r_done <= 1'b0;
    end else if (fire && o_last) begin
      l_done <= 1'b0;
      r_done <= 1'b0;
    end else begin
      if (take_l && lb_l) l_done <= 1'b1;
      if (take_r && rb_l) r_done <= 1'b1;
    end
  end
endmodule

// File: rtl/merge_out_stage.sv
`timescale 1ns/1ps
module merge_out_stage #(
  parameter int KEY_W = 16,
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i_valid,
  output logic             i_ready,
  input  logic [KEY_W-1:0] i_key,
  input  logic [VAL_W-1:0] i_val,
  input  logic             i_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [KEY_W-1:0] out_key,
  output logic [VAL_W-1:0] out_val,
  output logic             out_last,
  output logic             out_same_key,
  output logic             done
);
  logic have_prev;
  logic accept;

  assign i_ready = !out_valid || out_ready;
  assign accept  = i_valid && i_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_key      <= '0;
      out_val      <= '0;
      out_last     <= 1'b0;
      out_same_key <= 1'b0;
      have_prev    <= 1'b0;
    end else if (accept) begin
      out_valid    <= 1'b1;
      out_key      <= i_key;
      out_val      <= i_val;
      out_last     <= i_last;
      // out_key still holds the previously accepted key here
      out_same_key <= have_prev && (i_key == out_key);
      have_prev    <= !i_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= out_valid && out_ready && out_last;
  end
endmodule

// File: rtl/kway_merge_sorter.sv
`timescale 1ns/1ps
module kway_merge_sorter #(
  parameter int WAYS  = 4,
  parameter int KEY_W = 16,
  parameter int VAL_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [WAYS-1:0]             lane_valid,
  output logic [WAYS-1:0]             lane_ready,
  input  logic [WAYS-1:0][KEY_W-1:0]  lane_key,
  input  logic [WAYS-1:0][VAL_W-1:0]  lane_val,
  input  logic [WAYS-1:0]             lane_last,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [KEY_W-1:0]            out_key,
  output logic [VAL_W-1:0]            out_val,
  output logic                        out_last,
  output logic                        out_same_key,
  output logic                        done
);
  // heap-ordered stream nodes: 0 is the root, leaves WAYS-1 .. NODES-1
  localparam int NODES = 2 * WAYS - 1;
  localparam int LEAF0 = WAYS - 1;

  logic [NODES-1:0]            nv, nr, nl;
  logic [NODES-1:0][KEY_W-1:0] nk;
  logic [NODES-1:0][VAL_W-1:0] nd;

  for (genvar i = 0; i < WAYS; i++) begin : g_lane
    assign nv[LEAF0+i]  = lane_valid[i];
    assign nk[LEAF0+i]  = lane_key[i];
    assign nd[LEAF0+i]  = lane_val[i];
    assign nl[LEAF0+i]  = lane_last[i];
    assign lane_ready[i] = nr[LEAF0+i];
  end

  for (genvar n = 0; n < WAYS - 1; n++) begin : g_cell
    merge_cell #(.KEY_W(KEY_W), .VAL_W(VAL_W)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .l_valid(nv[2*n+1]),
      .l_ready(nr[2*n+1]),
      .l_key  (nk[2*n+1]),
      .l_val  (nd[2*n+1]),
      .l_last (nl[2*n+1]),
      .r_valid(nv[2*n+2]),
      .r_ready(nr[2*n+2]),
      .r_key  (nk[2*n+2]),
      .r_val  (nd[2*n+2]),
      .r_last (nl[2*n+2]),
      .o_valid(nv[n]),
      .o_ready(nr[n]),
      .o_key  (nk[n]),
      .o_val  (nd[n]),
      .o_last (nl[n])
    );
  end

  merge_out_stage #(.KEY_W(KEY_W), .VAL_W(VAL_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .i_valid     (nv[0]),
    .i_ready     (nr[0]),
    .i_key       (nk[0]),
    .i_val       (nd[0]),
    .i_last      (nl[0]),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_key     (out_key),
    .out_val     (out_val),
    .out_last    (out_last),
    .out_same_key(out_same_key),
    .done        (done)
  );
endmodule

// File: rtl/kway_merge_chk.sv
`timescale 1ns/1ps
module kway_merge_chk #(
  parameter int WAYS  = 4,
  parameter int KEY_W = 16,
  parameter int VAL_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WAYS-1:0]  lane_valid,
  input logic [WAYS-1:0]  lane_ready,
  input logic [WAYS-1:0]  lane_last,
  input logic             out_valid,
  input logic             out_ready,
  input logic [KEY_W-1:0] out_key,
  input logic [VAL_W-1:0] out_val,
  input logic             out_last,
  input logic             out_same_key,
  input logic             done
);
  logic             in_batch;
  logic [KEY_W-1:0] prev_key;
  logic             out_fire;

  assign out_fire = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_batch <= 1'b0;
      prev_key <= '0;
    end else if (out_fire) begin
      in_batch <= !out_last;
      prev_key <= out_key;
    end
  end

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_key) && $stable(out_val)
      && $stable(out_last) && $stable(out_same_key));

  // R1
  key_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && in_batch |-> out_key >= prev_key);

  // R5
  same_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && in_batch |-> out_same_key == (out_key == prev_key));

  // R5
  first_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !in_batch |-> !out_same_key);

  // R7
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_fire && out_last));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  for (genvar i = 0; i < WAYS; i++) begin : g_lane_chk
    // R8
    lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lane_valid[i] && lane_ready[i] && lane_last[i] |=> !lane_ready[i]);
  end
endmodule

bind kway_merge_sorter kway_merge_chk #(.WAYS(WAYS), .KEY_W(KEY_W), .VAL_W(VAL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lane_valid  (lane_valid),
  .lane_ready  (lane_ready),
  .lane_last   (lane_last),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_key     (out_key),
  .out_val     (out_val),
  .out_last    (out_last),
  .out_same_key(out_same_key),
  .done        (done)
);

// File: tb/test_kway_merge_sorter.sv
`timescale 1ns/1ps
module test_kway_merge_sorter;
  localparam int WAYS = 4;
  localparam int KW   = 16;
  localparam int VW   = 16;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic [WAYS-1:0]         lane_valid = '0;
  logic [WAYS-1:0]         lane_ready;
  logic [WAYS-1:0][KW-1:0] lane_key = '0;
  logic [WAYS-1:0][VW-1:0] lane_val = '0;
  logic [WAYS-1:0]         lane_last = '0;
  logic                    out_valid;
  logic                    out_ready = 1'b0;
  logic [KW-1:0]           out_key;
  logic [VW-1:0]           out_val;
  logic                    out_last;
  logic                    out_same_key;
  logic                    done;

  always #2.5 clk = ~clk;

  kway_merge_sorter #(.WAYS(WAYS), .KEY_W(KW), .VAL_W(VW)) i_kway_merge_sorter (
    .clk(clk), .rst_n(rst_n),
    .lane_valid(lane_valid), .lane_ready(lane_ready), .lane_key(lane_key),
    .lane_val(lane_val), .lane_last(lane_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_key(out_key),
    .out_val(out_val), .out_last(out_last), .out_same_key(out_same_key),
    .done(done)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] rng = 32'h1234_5678;

  logic [KW-1:0] qk [WAYS][$];
  logic [KW-1:0] ek [$];
  logic [VW-1:0] ev [$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit rbit();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng[3];
  endfunction

  // Reference: repeatedly take the smallest head key, lowest lane on ties.
  task automatic build_expect();
    int p [WAYS];
    int total = 0;
    ek.delete();
    ev.delete();
    for (int i = 0; i < WAYS; i++) begin
      p[i] = 0;
      total += qk[i].size();
    end
    for (int n = 0; n < total; n++) begin
      int best = -1;
      for (int i = 0; i < WAYS; i++)
        if (p[i] < qk[i].size())
          if (best < 0 || qk[i][p[i]] < qk[best][p[best]]) best = i;
      ek.push_back(qk[best][p[best]]);
      ev.push_back(VW'(best * 4096 + p[best]));
      p[best]++;
    end
  endtask

  task automatic run_batch(input bit gaps, input bit bp, output int span);
    int p [WAYS];
    bit hold_chk [WAYS];
    int total = 0;
    int got = 0;
    int cyc = 0;
    int first_cyc = -1;
    int last_cyc = -1;
    bit done_due = 1'b0;
    bit stalled = 1'b0;
    logic [KW-1:0] st_k = '0;
    logic [VW-1:0] st_v = '0;
    build_expect();
    for (int i = 0; i < WAYS; i++) begin
      p[i] = 0;
      hold_chk[i] = 1'b0;
      total += qk[i].size();
    end
    while ((got < total || done_due) && cyc < 2000) begin
      @(negedge clk);
      for (int i = 0; i < WAYS; i++) begin
        if (p[i] < qk[i].size()) begin
          lane_valid[i] = gaps ? rbit() : 1'b1;
          lane_key[i]   = qk[i][p[i]];
          lane_val[i]   = VW'(i * 4096 + p[i]);
          lane_last[i]  = (p[i] == qk[i].size() - 1);
        end else begin
          lane_valid[i] = 1'b0;
          lane_last[i]  = 1'b0;
        end
      end
      out_ready = bp ? rbit() : 1'b1;
      #2;
      // R7: done only on the cycle after the final record was taken
      if (done_due) begin
        chk(done == 1'b1, "R7 done pulse", done, 1);
        done_due = 1'b0;
      end else if (done) begin
        chk(1'b0, "R7 stray done", done, 0);
      end
      for (int i = 0; i < WAYS; i++) begin
        if (hold_chk[i]) begin
          chk(lane_ready[i] == 1'b0, "R8 lane ready after end", lane_ready[i], 0);
          hold_chk[i] = 1'b0;
        end
        if (lane_valid[i] && lane_ready[i]) begin
          if (lane_last[i]) hold_chk[i] = 1'b1;
          p[i]++;
        end
      end
      if (stalled) begin
        chk(out_valid && out_key == st_k && out_val == st_v, "R3 held under stall",
            out_val, st_v);
        stalled = 1'b0;
      end
      if (out_valid && !out_ready) begin
        stalled = 1'b1;
        st_k = out_key;
        st_v = out_val;
      end
      if (out_valid && out_ready) begin
        if (got < total) begin
          chk(out_key == ek[got], "R1 key order", out_key, ek[got]);
          chk(out_val == ev[got], "R2 tie order/payload", out_val, ev[got]);
          chk(out_same_key == (got > 0 && ek[got] == ek[got-1]), "R5 same-key flag",
              out_same_key, (got > 0 && ek[got] == ek[got-1]));
          chk(out_last == (got == total - 1), "R6 last flag", out_last, (got == total - 1));
        end else begin
          chk(1'b0, "R3 extra record", got + 1, total);
        end
        if (first_cyc < 0) first_cyc = cyc;
        last_cyc = cyc;
        if (got == total - 1) done_due = 1'b1;
        got++;
      end
      cyc++;
    end
    chk(got == total, "R3 record count", got, total);
    span = last_cyc - first_cyc + 1;
    for (int i = 0; i < WAYS; i++) begin
      lane_valid[i] = 1'b0;
      qk[i].delete();
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int span;
    logic [KW-1:0] k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R9
    chk(out_valid == 1'b0, "R9 out_valid after reset", out_valid, 0);
    chk(done == 1'b0, "R9 done after reset", done, 0);
    chk(lane_ready == '1, "R9 lane_ready after reset", lane_ready, 4'hf);

    // Interleaved distinct keys, no stalls: R1, R4
    qk[0] = '{1, 5, 9, 13};
    qk[1] = '{2, 6, 10, 14};
    qk[2] = '{3, 7, 11};
    qk[3] = '{4, 8, 12, 16, 20};
    run_batch(1'b0, 1'b0, span);
    chk(span == 16, "R4 one record per cycle", span, 16);

    // Many equal keys: R2 stability, R5 flag; ends on key 9
    qk[0] = '{5, 5, 7};
    qk[1] = '{5, 5, 7};
    qk[2] = '{5, 7, 7, 9};
    qk[3] = '{5, 5, 7};
    run_batch(1'b0, 1'b0, span);
    chk(span == 13, "R4 one record per cycle, ties", span, 13);

    // Opens on the previous batch's last key: R5 first record flag clear
    qk[0] = '{9};
    qk[1] = '{9};
    qk[2] = '{9};
    qk[3] = '{9};
    run_batch(1'b0, 1'b0, span);

    // One long list against single-record lists, with gaps: R6
    for (int j = 0; j < 12; j++) qk[0].push_back(KW'(2 * j));
    qk[1] = '{100};
    qk[2] = '{3};
    qk[3] = '{3};
    run_batch(1'b1, 1'b0, span);

    // Random lists with gaps and back-pressure: R3
    for (int b = 0; b < 4; b++) begin
      for (int i = 0; i < WAYS; i++) begin
        k = KW'(rng[5:0]);
        for (int j = 0; j < 6 + int'(rng[1:0]) + i; j++) begin
          void'(rbit());
          k = k + KW'(rng[1:0]);
          qk[i].push_back(k);
        end
      end
      run_batch(1'b1, 1'b1, span);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule